// File: doc/BRIEF.md
# Waveform Playback Trigger Controller

This block sits in front of a waveform playback engine and decides when that engine runs. It takes an asynchronous trigger level, a two-bit trigger mode, separate arm and disarm strobes and a playback-finished strobe from the engine. It produces a run enable that the engine follows and a one-cycle start pulse that tells the engine to restart at the top of its sequence.

Three trigger behaviours come from one four-state controller (idle, armed, running, finished). Gated mode runs the engine only while the synchronised trigger is high. Single mode starts one pass of the sequence on a trigger rising edge and stops after the engine reports completion; it must be armed again before it reacts to another trigger. Free-running mode starts on a trigger rising edge and then keeps the engine running however many times it completes the sequence. The trigger input is synchronised by a chain of flip-flops whose length is a parameter.

Top module: `wavetrig_ctrl`

## Requirements
- R1: After reset, `run_en` and `start_pulse` are 0 and the block is idle; no trigger starts playback until `arm` has been seen.
- R2: With the default two-stage synchroniser, a trigger change driven before clock edge k first influences the controller at edge k+2, so `run_en` rises after edge k+2 (third edge counting edge k).
- R3: Gated mode (`mode` = 0): while armed, a high synchronised trigger starts playback; while running, a low synchronised trigger stops it and returns to armed, so a later high level starts it again without a new arm.
- R4: Single mode (`mode` = 1): a synchronised trigger rising edge while armed starts playback; it stays running until `play_done` is seen at a clock edge, after which `run_en` is 0 from that edge on.
- R5: Free-running mode (`mode` = 2): a synchronised trigger rising edge while armed starts playback, which then stays on regardless of `play_done` and further triggers until disarmed.
- R6: Triggers have no effect while idle or finished; `arm` has no effect while armed or running; only `arm` leaves the finished state, to armed.
- R7: `disarm` has priority over every other input: when it is high at a clock edge, `run_en` is 0 after that edge, and the block is idle.
- R8: `start_pulse` is high for exactly the first cycle of each run, i.e. each cycle in which `run_en` is 1 and was 0 in the cycle before; it is never high while `run_en` is 0.
- R9: `mode` = 3 is reserved: in it the armed state never starts playback.
- R10: In single and free-running modes only a rising edge counts: a trigger already high when the block is armed does not start playback until it has gone low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous trigger level |
| mode | input | 2 | Trigger mode: 0 gated, 1 single, 2 free-running, 3 reserved |
| arm | input | 1 | Arm strobe, leaves idle or finished for armed |
| disarm | input | 1 | Disarm strobe, forces idle |
| play_done | input | 1 | Engine has finished one pass of its sequence |
| run_en | output | 1 | Playback engine run enable |
| start_pulse | output | 1 | One-cycle restart request at each run start |

## Verification
The interesting collisions are a `disarm` landing in the same cycle as a trigger edge, an `arm` or a `play_done`, and a `play_done` landing in the cycle a single-mode run would end anyway while the trigger changes. Directed cases put `disarm` and `arm` on one edge and `play_done` on a running free-running pass, and a long seeded random phase drives all strobes with independent probabilities so such overlaps occur many times in every mode. Each cycle the outputs are compared with a bench reference model built from the requirements, where `disarm` wins over everything and the single-mode completion wins over the trigger level.

// File: rtl/wavetrig_pkg.sv
package wavetrig_pkg;

   typedef enum logic [1:0] {
      MODE_GATED  = 2'd0,
      MODE_SINGLE = 2'd1,
      MODE_FREE   = 2'd2,
      MODE_RSVD   = 2'd3
   } trig_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2,
      ST_DONE  = 2'd3
   } ctl_state_e;

endpackage

// File: rtl/wavetrig_sync.sv
module wavetrig_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("wavetrig_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= din;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RST_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/wavetrig_edge.sv
module wavetrig_edge #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= RST_VAL;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/wavetrig_fsm.sv
module wavetrig_fsm
   import wavetrig_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_lvl,
   input  logic              trig_rise,
   input  logic [MODE_W-1:0] mode,
   input  logic              arm,
   input  logic              disarm,
   input  logic              play_done,
   output logic              run_en,
   output logic              start_pulse
);

   generate
      if (MODE_W != 2) begin : g_bad_mode_w
         $error("wavetrig_fsm: MODE_W must be 2");
      end
   endgenerate

   trig_mode_e mode_e;
   ctl_state_e state_q, state_d;
   logic       run_prev_q;

   assign mode_e = trig_mode_e'(mode[1:0]);

   always_comb begin
      state_d = state_q;
      if (disarm) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (arm) state_d = ST_ARMED;
            ST_ARMED: begin
               unique case (mode_e)
                  MODE_GATED:  if (trig_lvl)  state_d = ST_RUN;
                  MODE_SINGLE: if (trig_rise) state_d = ST_RUN;
                  MODE_FREE:   if (trig_rise) state_d = ST_RUN;
                  default:     state_d = ST_ARMED;
               endcase
            end
            ST_RUN: begin
               unique case (mode_e)
                  MODE_GATED:  if (!trig_lvl) state_d = ST_ARMED;
                  MODE_SINGLE: if (play_done) state_d = ST_DONE;
                  default:     state_d = ST_RUN;
               endcase
            end
            ST_DONE: if (arm) state_d = ST_ARMED;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         run_prev_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         run_prev_q <= run_en;
      end
   end

   assign run_en      = (state_q == ST_RUN);
   assign start_pulse = run_en & ~run_prev_q;

endmodule

// File: rtl/wavetrig_ctrl.sv
module wavetrig_ctrl #(
   parameter int SYNC_STAGES = 2,
   parameter int MODE_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_in,
   input  logic [MODE_W-1:0] mode,
   input  logic              arm,
   input  logic              disarm,
   input  logic              play_done,
   output logic              run_en,
   output logic              start_pulse
);

   logic trig_sync;
   logic trig_rise;

   wavetrig_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (trig_in),
      .dout  (trig_sync)
   );

   wavetrig_edge #(
      .RST_VAL (1'b0)
   ) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (trig_sync),
      .rise  (trig_rise)
   );

   wavetrig_fsm #(
      .MODE_W (MODE_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_lvl    (trig_sync),
      .trig_rise   (trig_rise),
      .mode        (mode),
      .arm         (arm),
      .disarm      (disarm),
      .play_done   (play_done),
      .run_en      (run_en),
      .start_pulse (start_pulse)
   );

endmodule

// File: rtl/wavetrig_chk.sv
module wavetrig_chk #(
   parameter int MODE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] mode,
   input logic              disarm,
   input logic              play_done,
   input logic              trig_lvl,
   input logic              run_en,
   input logic              start_pulse
);

   assert_pulse_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> run_en);

   assert_pulse_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   assert_pulse_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en ##1 run_en) |-> start_pulse);

   assert_disarm_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      disarm |=> !run_en);

   assert_gate_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode == 2'd0 && !trig_lvl) |=> !run_en);

   assert_single_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode == 2'd1 && play_done) |=> !run_en);

   assert_free_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && mode == 2'd2 && !disarm) |=> run_en);

   assert_reserved_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && mode == 2'd3) |=> !run_en);

endmodule

bind wavetrig_ctrl wavetrig_chk #(.MODE_W(MODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode),
   .disarm      (disarm),
   .play_done   (play_done),
   .trig_lvl    (trig_sync),
   .run_en      (run_en),
   .start_pulse (start_pulse)
);

// File: tb/wavetrig_ctrl_bench.sv
module wavetrig_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       trig_in = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       arm = 1'b0;
   logic       disarm = 1'b0;
   logic       play_done = 1'b0;
   logic       run_en;
   logic       start_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   string cur_tag = "R1";

   // bench reference model: 0 idle, 1 armed, 2 running, 3 finished
   int   m_st = 0;
   logic m_s1 = 1'b0, m_s2 = 1'b0, m_q = 1'b0, m_prev = 1'b0;

   always #10 clk = ~clk;

   wavetrig_ctrl u_wavetrig_ctrl (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .mode(mode),
      .arm(arm), .disarm(disarm), .play_done(play_done),
      .run_en(run_en), .start_pulse(start_pulse));

   function automatic int next_state(int st, logic lvl, logic rise, logic [1:0] md,
                                     logic a, logic d, logic pd);
      if (d) return 0;
      case (st)
         0: return a ? 1 : 0;
         1: begin
            if (md == 2'd0) return lvl ? 2 : 1;
            if (md == 2'd1 || md == 2'd2) return rise ? 2 : 1;
            return 1;
         end
         2: begin
            if (md == 2'd0) return lvl ? 2 : 1;
            if (md == 2'd1) return pd ? 3 : 2;
            return 2;
         end
         default: return a ? 1 : 3;
      endcase
   endfunction

   task automatic check(string tag, logic act, logic exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_step();
      int   nx;
      logic rise;
      rise = m_s2 & ~m_q;
      nx = next_state(m_st, m_s2, rise, mode, arm, disarm, play_done);
      m_q  = m_s2;
      m_s2 = m_s1;
      m_s1 = trig_in;
      m_prev = (m_st == 2);
      m_st = nx;
   endtask

   // one clock: model and outputs compared 1 ns after the edge
   task automatic cyc();
      logic er, es;
      @(posedge clk);
      #1;
      model_step();
      er = (m_st == 2);
      es = er & ~m_prev;
      check(cur_tag, run_en, er, "run_en vs model");
      check(cur_tag, start_pulse, es, "start_pulse vs model");
   endtask

   task automatic cycs(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic do_arm();
      arm = 1'b1; cyc(); arm = 1'b0;
   endtask

   task automatic do_disarm();
      disarm = 1'b1; cyc(); disarm = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      #25;
      cur_tag = "R1";
      check("R1", run_en, 1'b0, "run_en in reset");
      check("R1", start_pulse, 1'b0, "start_pulse in reset");
      @(negedge clk); rst_n = 1'b1;
      // R6: triggers while idle do nothing
      cur_tag = "R6";
      trig_in = 1'b1; cycs(4); trig_in = 1'b0; cycs(4);
      check("R6", run_en, 1'b0, "idle ignores trigger");

      // R2 / R3 / R8: gated mode latency and release
      cur_tag = "R3"; mode = 2'd0;
      do_arm(); cycs(2);
      trig_in = 1'b1;
      cyc(); cyc();
      check("R2", run_en, 1'b0, "run_en two edges after trigger");
      cyc();
      check("R2", run_en, 1'b1, "run_en three edges after trigger");
      check("R8", start_pulse, 1'b1, "start pulse on first run cycle");
      cyc();
      check("R8", start_pulse, 1'b0, "start pulse one cycle only");
      arm = 1'b1; cyc(); arm = 1'b0;
      check("R6", run_en, 1'b1, "arm while running ignored");
      trig_in = 1'b0; cycs(3);
      check("R3", run_en, 1'b0, "gated release stops run");
      trig_in = 1'b1; cycs(3);
      check("R3", run_en, 1'b1, "gated restarts without re-arm");
      check("R8", start_pulse, 1'b1, "second run start pulse");
      trig_in = 1'b0; cycs(3);

      // R4 / R6 / R10: single mode
      cur_tag = "R4"; do_disarm(); mode = 2'd1; do_arm();
      trig_in = 1'b1; cycs(3);
      check("R4", run_en, 1'b1, "single starts on rise");
      trig_in = 1'b0; cycs(6);
      check("R4", run_en, 1'b1, "single runs until done");
      play_done = 1'b1; cyc(); play_done = 1'b0;
      check("R4", run_en, 1'b0, "single stops on done");
      cur_tag = "R6";
      trig_in = 1'b1; cycs(4);
      check("R6", run_en, 1'b0, "finished ignores trigger");
      cur_tag = "R10";
      do_arm(); cycs(4);
      check("R10", run_en, 1'b0, "high level at arm does not start");
      trig_in = 1'b0; cycs(3); trig_in = 1'b1; cycs(3);
      check("R10", run_en, 1'b1, "fresh rise starts");
      trig_in = 1'b0; cycs(2);

      // R5: free-running ignores done and retriggers
      cur_tag = "R5"; do_disarm(); mode = 2'd2; do_arm();
      trig_in = 1'b1; cycs(3); trig_in = 1'b0;
      for (int i = 0; i < 5; i++) begin
         play_done = 1'b1; cyc(); play_done = 1'b0; cycs(3);
      end
      check("R5", run_en, 1'b1, "free-running ignores done");
      check("R5", start_pulse, 1'b0, "no restart pulse while free-running");

      // R7: disarm with arm and done in the same cycle
      cur_tag = "R7";
      disarm = 1'b1; arm = 1'b1; play_done = 1'b1; cyc();
      disarm = 1'b0; arm = 1'b0; play_done = 1'b0;
      check("R7", run_en, 1'b0, "disarm wins, run dropped next cycle");
      trig_in = 1'b1; cycs(4); trig_in = 1'b0; cycs(2);
      check("R7", run_en, 1'b0, "idle after disarm");

      // R9: reserved mode never starts
      cur_tag = "R9"; mode = 2'd3; do_arm();
      for (int i = 0; i < 4; i++) begin
         trig_in = 1'b1; cycs(3); trig_in = 1'b0; cycs(3);
      end
      check("R9", run_en, 1'b0, "reserved mode never runs");

      // seeded random phase checked cycle by cycle against the model
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(7) == 0) trig_in = ~trig_in;
         arm       = ($urandom_range(9) == 0);
         disarm    = ($urandom_range(39) == 0);
         play_done = ($urandom_range(11) == 0);
         if ($urandom_range(199) == 0) mode = 2'($urandom_range(3));
         case (mode)
            2'd0: cur_tag = "R3";
            2'd1: cur_tag = "R4";
            2'd2: cur_tag = "R5";
            default: cur_tag = "R9";
         endcase
         cyc();
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule